// File: doc/BRIEF.md
# Fully Associative FIFO Victim Buffer

This block keeps a handful of blocks that a set-associative first-level data cache has just thrown out, so a quick re-reference can be served without going to the second level. Only tags and dirty status are held, never data. Entries are found by comparing the block address (the byte address with its offset bits removed) against every valid slot. Replacement is strictly first-in first-out.

The first level consults the buffer only after its own miss. It presents the missing address on the lookup port together with its own victim: the victim's block address, and whether that way was valid and dirty. On a hit, the result comes back in the same cycle with the found entry's dirty bit. At the clock edge the found entry leaves the buffer and the victim, if valid, is written as the newest entry. On a miss nothing changes. Once the lower level has supplied the block, the first level pushes its victim through the insert strobe. If the buffer is full, the oldest entry is pushed out. Only a dirty one appears on the eviction output for the second level; a clean one is dropped. Capacity is a parameter from zero to four. At zero, every lookup misses and each valid victim goes straight to the eviction path.

Top module: `fifo_victim_buf`

## Requirements
- R1: After reset the buffer is empty: every lookup misses and `evictValid` is low.
- R2: With `lookupValid` high, `lookupHit` rises in the same cycle when `lookupAddr` with its low `OFF_W` offset bits ignored matches a held entry, and `lookupDirty` then gives that entry's dirty bit.
- R3: On a hit the found entry is removed at the clock edge. A valid victim (`victValid`=1) is stored as the newest entry in FIFO order; an invalid victim leaves the buffer one entry shorter. A hit never produces an eviction.
- R4: An insert (`insertValid`=1, `victValid`=1) into a buffer that is not full stores the victim as the newest entry and produces no eviction.
- R5: An insert into a full buffer removes the oldest entry. If that entry is dirty, `evictValid` is high for the one cycle after the edge, with `evictAddr` equal to its block address and zero offset bits. A clean oldest entry is dropped with no eviction.
- R6: An insert with `victValid`=0 leaves the buffer unchanged and produces no eviction.
- R7: When `lookupValid` and `insertValid` are both high in a cycle, only the lookup acts; the insert is ignored.
- R8: With `ENTRIES`=0 every lookup misses. A valid dirty victim on insert appears on `evictValid`/`evictAddr` the next cycle, and a clean one is dropped.
- R9: The dirty bit given with an entry, on a hit or on eviction, is the one it was stored with.
- R10: With `lookupValid` low, `lookupHit` and `lookupDirty` stay low and the buffer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request after a first-level miss |
| lookupAddr | input | ADDR_W | Byte address being looked up |
| lookupHit | output | 1 | Lookup matched a held entry (same cycle) |
| lookupDirty | output | 1 | Dirty bit of the matched entry |
| insertValid | input | 1 | Push the first-level victim into the buffer |
| victValid | input | 1 | First-level victim way held a valid block |
| victAddr | input | ADDR_W | Byte address of the first-level victim |
| victDirty | input | 1 | First-level victim is dirty |
| evictValid | output | 1 | Dirty block leaving toward the second level |
| evictAddr | output | ADDR_W | Block-aligned address of the leaving block |

## Verification
Lookup results are combinational: the bench drives a lookup just after a falling edge and samples `lookupHit`/`lookupDirty` two nanoseconds later, before the rising edge that commits the swap. Evictions come through one register. The bench therefore samples `evictValid`/`evictAddr` shortly after the rising edge that took the insert, and removes its stimulus only after that sample. FIFO order and stored dirty bits are observed only at the ports, through later hits and through the sequence of evictions. The bench sweeps all sixteen dirty patterns of a full four-entry buffer, and a zero-capacity instance shares the same stimulus.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic       doRemove;      // take one slot out, compacting above it
    logic [2:0] removeIdx;     // slot to take out (0 = oldest)
    logic       doAppend;      // write victim as newest entry
    logic       evictHead;     // oldest entry leaves dirty toward level two
    logic       evictIncoming; // zero capacity: victim passes straight through
  } vbStrobe_t;
endpackage

// File: rtl/vb_datapath.sv
module vb_datapath
  import vb_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 6,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] victAddr,
  input  logic              victDirty,
  input  vbStrobe_t         strobe,
  output logic              hitAny,
  output logic [2:0]        hitIdx,
  output logic              hitDirty,
  output logic              full,
  output logic              headDirty,
  output logic              evictValid,
  output logic [ADDR_W-1:0] evictAddr
);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int SLOTS = (ENTRIES == 0) ? 1 : ENTRIES;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [BLK_W-1:0] tagQ   [SLOTS];
  logic             dirtyQ [SLOTS];
  logic [CNT_W-1:0] countQ;
  logic [BLK_W-1:0] tagD   [SLOTS];
  logic             dirtyD [SLOTS];
  logic [CNT_W-1:0] countD;

  logic [BLK_W-1:0] lookupBlk;
  logic [BLK_W-1:0] victBlk;
  assign lookupBlk = lookupAddr[ADDR_W-1:OFF_W];
  assign victBlk   = victAddr[ADDR_W-1:OFF_W];

  // Parallel compare against every occupied slot.
  always_comb begin
    hitAny   = 1'b0;
    hitIdx   = 3'd0;
    hitDirty = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (CNT_W'(i) < countQ && tagQ[i] == lookupBlk && !hitAny) begin
        hitAny   = 1'b1;
        hitIdx   = 3'(i);
        hitDirty = dirtyQ[i];
      end
    end
  end

  assign full      = (countQ == CNT_W'(ENTRIES));
  assign headDirty = dirtyQ[0];

  // Remove-then-append: slots stay packed with the oldest at index 0.
  always_comb begin
    logic [CNT_W-1:0] cntMid;
    cntMid = countQ - (strobe.doRemove ? CNT_W'(1) : CNT_W'(0));
    for (int j = 0; j < SLOTS; j++) begin
      int srcIdx;
      srcIdx    = (strobe.doRemove && j >= int'(strobe.removeIdx)) ? j + 1 : j;
      tagD[j]   = tagQ[j];
      dirtyD[j] = dirtyQ[j];
      for (int k = 0; k < SLOTS; k++) begin
        if (k == srcIdx) begin
          tagD[j]   = tagQ[k];
          dirtyD[j] = dirtyQ[k];
        end
      end
      if (strobe.doAppend && CNT_W'(j) == cntMid) begin
        tagD[j]   = victBlk;
        dirtyD[j] = victDirty;
      end
    end
    countD = cntMid + (strobe.doAppend ? CNT_W'(1) : CNT_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countQ <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        tagQ[i]   <= '0;
        dirtyQ[i] <= 1'b0;
      end
    end else begin
      countQ <= countD;
      for (int i = 0; i < SLOTS; i++) begin
        tagQ[i]   <= tagD[i];
        dirtyQ[i] <= dirtyD[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evictValid <= 1'b0;
      evictAddr  <= '0;
    end else begin
      evictValid <= strobe.evictHead | strobe.evictIncoming;
      if (strobe.evictHead)
        evictAddr <= {tagQ[0], {OFF_W{1'b0}}};
      else if (strobe.evictIncoming)
        evictAddr <= {victBlk, {OFF_W{1'b0}}};
    end
  end
endmodule

// File: rtl/vb_ctrl.sv
module vb_ctrl
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic       lookupValid,
  input  logic       insertValid,
  input  logic       victValid,
  input  logic       victDirty,
  input  logic       hitAny,
  input  logic [2:0] hitIdx,
  input  logic       full,
  input  logic       headDirty,
  output vbStrobe_t  strobe
);
  always_comb begin
    strobe = '0;
    if (lookupValid) begin
      // Lookup wins over a concurrent insert; a miss changes nothing.
      if (hitAny) begin
        strobe.doRemove  = 1'b1;
        strobe.removeIdx = hitIdx;
        strobe.doAppend  = victValid;
      end
    end else if (insertValid && victValid) begin
      if (ENTRIES == 0) begin
        strobe.evictIncoming = victDirty;
      end else if (full) begin
        strobe.doRemove  = 1'b1;
        strobe.removeIdx = 3'd0;
        strobe.doAppend  = 1'b1;
        strobe.evictHead = headDirty;
      end else begin
        strobe.doAppend = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fifo_victim_buf.sv
module fifo_victim_buf
  import vb_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 6,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic              lookupDirty,
  input  logic              insertValid,
  input  logic              victValid,
  input  logic [ADDR_W-1:0] victAddr,
  input  logic              victDirty,
  output logic              evictValid,
  output logic [ADDR_W-1:0] evictAddr
);
  vbStrobe_t  strobe;
  logic       hitAny;
  logic [2:0] hitIdx;
  logic       hitDirty;
  logic       full;
  logic       headDirty;

  vb_ctrl #(.ENTRIES(ENTRIES)) ctrl (
    .lookupValid(lookupValid), .insertValid(insertValid),
    .victValid(victValid), .victDirty(victDirty),
    .hitAny(hitAny), .hitIdx(hitIdx), .full(full),
    .headDirty(headDirty), .strobe(strobe)
  );

  vb_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) dp (
    .clk(clk), .rst_n(rst_n), .lookupAddr(lookupAddr),
    .victAddr(victAddr), .victDirty(victDirty), .strobe(strobe),
    .hitAny(hitAny), .hitIdx(hitIdx), .hitDirty(hitDirty),
    .full(full), .headDirty(headDirty),
    .evictValid(evictValid), .evictAddr(evictAddr)
  );

  assign lookupHit   = lookupValid & hitAny;
  assign lookupDirty = lookupValid & hitAny & hitDirty;
endmodule

// File: rtl/vb_chk.sv
module vb_chk #(
  parameter int ENTRIES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic lookupValid,
  input logic lookupHit,
  input logic lookupDirty,
  input logic insertValid,
  input logic victValid,
  input logic evictValid
);
  // R10
  lookup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookupHit |-> lookupValid);

  // R9
  dirty_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookupDirty |-> lookupHit);

  // R5
  evict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evictValid |-> $past(insertValid && victValid && !lookupValid));

  // R6
  no_evict_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !victValid |=> !evictValid);

  // R3
  no_evict_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookupHit |=> !evictValid);

  generate
    if (ENTRIES == 0) begin : gZero
      // R8
      zero_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lookupHit);
    end
  endgenerate
endmodule

bind fifo_victim_buf vb_chk #(.ENTRIES(ENTRIES)) chk (
  .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid),
  .lookupHit(lookupHit), .lookupDirty(lookupDirty),
  .insertValid(insertValid), .victValid(victValid),
  .evictValid(evictValid)
);

// File: tb/tb_fifo_victim_buf.sv
module tb_fifo_victim_buf;
  localparam int AW = 16;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookupValid = 1'b0, insertValid = 1'b0, victValid = 1'b0, victDirty = 1'b0;
  logic [AW-1:0] lookupAddr = '0, victAddr = '0;
  logic lookupHit, lookupDirty, evictValid;
  logic [AW-1:0] evictAddr;
  logic hitZ, dirtyZ, evictZ;
  logic [AW-1:0] evictAddrZ;

  int checks = 0;
  int errors = 0;
  logic sHit, sDirty, sEv, sEvZ, sHitZ;
  logic [AW-1:0] sEa, sEaZ;

  always #10 clk = ~clk;

  fifo_victim_buf #(.ADDR_W(AW), .OFF_W(OW), .ENTRIES(4)) dut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupHit(lookupHit), .lookupDirty(lookupDirty), .insertValid(insertValid),
    .victValid(victValid), .victAddr(victAddr), .victDirty(victDirty),
    .evictValid(evictValid), .evictAddr(evictAddr));

  fifo_victim_buf #(.ADDR_W(AW), .OFF_W(OW), .ENTRIES(0)) dutZero (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupHit(hitZ), .lookupDirty(dirtyZ), .insertValid(insertValid),
    .victValid(victValid), .victAddr(victAddr), .victDirty(victDirty),
    .evictValid(evictZ), .evictAddr(evictAddrZ));

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clearIn();
    lookupValid = 1'b0; insertValid = 1'b0; victValid = 1'b0; victDirty = 1'b0;
    lookupAddr = '0; victAddr = '0;
  endtask

  // Lookup: result sampled before the committing edge; evict sampled after it.
  task automatic lookup(logic [AW-1:0] a, logic vv, logic [AW-1:0] va, logic vd);
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = a; victValid = vv; victAddr = va; victDirty = vd;
    #2; sHit = lookupHit; sDirty = lookupDirty; sHitZ = hitZ;
    @(posedge clk); #2; sEv = evictValid; sEvZ = evictZ;
    clearIn();
  endtask

  task automatic insert(logic [AW-1:0] va, logic vv, logic vd, logic alsoLookup);
    @(negedge clk);
    insertValid = 1'b1; victValid = vv; victAddr = va; victDirty = vd;
    lookupValid = alsoLookup; lookupAddr = 16'hF000;
    @(posedge clk); #2;
    sEv = evictValid; sEa = evictAddr; sEvZ = evictZ; sEaZ = evictAddrZ;
    clearIn();
  endtask

  function automatic logic [AW-1:0] blkA(int i); return AW'(16'h1000 + i * 16); endfunction
  function automatic logic [AW-1:0] blkC(int i); return AW'(16'h2000 + i * 16); endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    // R1: empty after reset
    chk("R1 evict", AW'(evictValid), '0);
    for (int i = 0; i < 4; i++) begin
      lookup(blkA(i), 1'b0, '0, 1'b0);
      chk("R1 miss", AW'(sHit), '0);
    end

    // Sweep all dirty patterns of a full buffer.
    for (int p = 0; p < 16; p++) begin
      doReset();
      for (int i = 0; i < 4; i++) begin
        insert(blkA(i), 1'b1, p[i], 1'b0);
        chk("R4 no evict", AW'(sEv), '0);
        chk("R8 zero evict", AW'(sEvZ), AW'(p[i]));
        if (p[i]) chk("R8 zero addr", sEaZ, blkA(i));
      end
      // Hit each with itself as victim; order returns to A0..A3.
      for (int i = 0; i < 4; i++) begin
        lookup(blkA(i) | AW'(i + 3), 1'b1, blkA(i), p[i]);
        chk("R2 hit", AW'(sHit), 1);
        chk("R9 dirty on hit", AW'(sDirty), AW'(p[i]));
        chk("R8 zero miss", AW'(sHitZ), '0);
        chk("R3 no evict on hit", AW'(sEv), '0);
      end
      for (int i = 0; i < 4; i++) begin
        insert(blkC(i), 1'b1, 1'b0, 1'b0);
        chk("R5 evict dirty head", AW'(sEv), AW'(p[i]));
        if (p[i]) chk("R5 evict addr", sEa, blkA(i));
      end
    end

    // R3: swap makes the victim the newest entry.
    doReset();
    for (int i = 0; i < 4; i++) insert(blkA(i), 1'b1, 1'b0, 1'b0);
    lookup(blkA(1), 1'b1, 16'h3005, 1'b1);
    chk("R3 hit", AW'(sHit), 1);
    for (int i = 0; i < 4; i++) begin
      insert(blkC(i), 1'b1, 1'b1, 1'b0);
      chk("R3 swap order", AW'(sEv), AW'(i == 3));
      if (i == 3) chk("R3 swap addr", sEa, 16'h3000);
    end

    // R3: hit with invalid victim shrinks the buffer.
    doReset();
    for (int i = 0; i < 3; i++) insert(blkA(i), 1'b1, 1'b1, 1'b0);
    lookup(blkA(0), 1'b0, '0, 1'b0);
    chk("R3 hit invalid victim", AW'(sHit), 1);
    lookup(blkA(0), 1'b0, '0, 1'b0);
    chk("R3 removed", AW'(sHit), '0);
    insert(blkC(0), 1'b1, 1'b0, 1'b0);
    insert(blkC(1), 1'b1, 1'b0, 1'b0);
    chk("R3 room freed", AW'(sEv), '0);
    insert(blkC(2), 1'b1, 1'b0, 1'b0);
    chk("R3 head A1", AW'(sEv), 1);
    chk("R3 head A1 addr", sEa, blkA(1));

    // R6: invalid victim on insert is ignored.
    doReset();
    for (int i = 0; i < 4; i++) insert(blkA(i), 1'b1, 1'b1, 1'b0);
    insert(blkC(0), 1'b0, 1'b1, 1'b0);
    chk("R6 no evict", AW'(sEv), '0);
    chk("R6 zero no evict", AW'(sEvZ), '0);
    lookup(blkC(0), 1'b0, '0, 1'b0);
    chk("R6 not stored", AW'(sHit), '0);
    insert(blkC(1), 1'b1, 1'b0, 1'b0);
    chk("R6 head kept", sEa, blkA(0));

    // R7: concurrent lookup (miss) and insert: insert ignored.
    doReset();
    for (int i = 0; i < 4; i++) insert(blkA(i), 1'b1, 1'b1, 1'b0);
    insert(blkC(0), 1'b1, 1'b1, 1'b1);
    chk("R7 no evict", AW'(sEv), '0);
    chk("R7 zero no evict", AW'(sEvZ), '0);
    lookup(blkC(0), 1'b0, '0, 1'b0);
    chk("R7 not stored", AW'(sHit), '0);

    // R10: no request, no hit and no change.
    @(negedge clk);
    lookupAddr = blkA(1); victValid = 1'b1; victAddr = blkC(3);
    #2;
    chk("R10 hit low", AW'(lookupHit), '0);
    chk("R10 dirty low", AW'(lookupDirty), '0);
    @(posedge clk); #2; clearIn();
    lookup(blkA(1), 1'b1, blkA(1), 1'b1);
    chk("R10 entry kept", AW'(sHit), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule